// File: doc/BRIEF.md
# Power Mode Controller

This block governs the reduced-power states of a small microcontroller and qualifies its external reset pin. Software sets one of two mode bits in an eight-bit power-control register. In the light-sleep (idle) state, the clock enable for the processor core is withdrawn while the peripheral clock enable stays on. In the deep-sleep (power-down) state, both enables are withdrawn. In each state the block drives a pair of override outputs, which force the external address-latch and program-fetch strobes to the level that state calls for.

The reset pin passes through a synchronizer and a hold counter. An internal reset is raised only after the pin has been seen high for two full machine cycles of twelve oscillator periods each. That internal reset clears the power-control register, which ends either sleep state. While it is asserted, it also captures the external-access strap. An enabled, pending interrupt ends light sleep but has no effect on deep sleep.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After the power-on reset `rst`, the register reads 0x00, both clock enables are 1, the strobe override is 0, the internal reset is 0 and the captured strap is 0.
- R2: In run mode (bits 0 and 1 clear), a write stores bit 0 (idle), bit 1 (power-down), bits 2 and 3 (general flags) and bit 7 (baud doubler). Bits 6:4 always read 0. The new value and the outputs appear after the same clock edge that samples the write.
- R3: With bit 0 set, `cpu_ce_o` is 0, `per_ce_o` is 1, `strobe_hold_o` is 1 and `strobe_level_o` is 1.
- R4: With bit 1 set, `cpu_ce_o` and `per_ce_o` are 0, `strobe_hold_o` is 1 and `strobe_level_o` is 0.
- R5: A write that sets both bit 0 and bit 1 enters power-down only, so bit 0 reads 0. The two mode bits are never both set.
- R6: `wake_i` sampled high in idle clears bit 0 at that edge and leaves the other bits unchanged. In power-down and in run mode, `wake_i` has no effect.
- R7: Register writes are ignored while bit 0 or bit 1 is set.
- R8: `rst_int_o` rises only if `rst_pin_i` has been sampled high on HOLD_MCYC*OSC_PER_MCYC (default 24) consecutive clock edges. It becomes 1 after the edge two cycles past the last of those samples. A shorter pulse never raises it. It falls after the second edge past the first low sample.
- R9: While `rst_int_o` is high, the next edge clears the register to 0x00, which ends idle or power-down and restores both clock enables.
- R10: `ea_o` loads `ea_pin_i` on each edge at which `rst_int_o` is high, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| rst_pin_i | input | 1 | Asynchronous external reset pin |
| ea_pin_i | input | 1 | External-access strap level |
| wr_en_i | input | 1 | Power-control register write strobe |
| wr_data_i | input | 8 | Power-control register write data |
| wake_i | input | 1 | An enabled interrupt is pending |
| cpu_ce_o | output | 1 | Processor core clock enable |
| per_ce_o | output | 1 | Peripheral clock enable |
| strobe_hold_o | output | 1 | Overrides drive the strobe pins |
| strobe_level_o | output | 1 | Level the overridden strobes take |
| rst_int_o | output | 1 | Qualified internal reset |
| ea_o | output | 1 | Strap level captured during reset |
| pcon_o | output | 8 | Power-control register contents |

## Verification
Every one of the 256 write values is applied from run mode. The check confirms that the masked, priority-resolved register value and the four mode outputs separate idle, power-down and plain flag writes. From each resulting state the bench tries the exits that should fail (a second write, a wake in power-down or run mode) and the exit that should succeed (wake from idle, reset from power-down). This distinguishes the two sleep states by their exit conditions as well as by their output levels. A sweep of reset-pin pulse lengths from 1 to 30 cycles locates the hold threshold exactly and the edge on which the internal reset rises. The same sweep shows whether the strap was captured and whether a pending idle state was cleared.

// File: rtl/pwr_pkg.sv
package pwr_pkg;
  localparam int PCON_W  = 8;
  localparam int BIT_IDL = 0;
  localparam int BIT_PD  = 1;
  localparam logic [PCON_W-1:0] WR_MASK = 8'h8F;

  typedef enum logic [1:0] {
    MODE_RUN   = 2'd0,
    MODE_IDLE  = 2'd1,
    MODE_PDOWN = 2'd2
  } pwr_mode_e;

  function automatic pwr_mode_e decode_mode(input logic [PCON_W-1:0] r);
    if (r[BIT_PD])       return MODE_PDOWN;
    else if (r[BIT_IDL]) return MODE_IDLE;
    else                 return MODE_RUN;
  endfunction
endpackage

// File: rtl/pwr_rst_qual.sv
module pwr_rst_qual #(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYC    = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  output logic rst_q_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(HOLD_CYC);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   pin_s;
  logic [CNT_W-1:0]       cnt_q, cnt_d;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '0;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
  end

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_comb begin
    if (!pin_s)                cnt_d = '0;
    else if (cnt_q == CNT_TOP) cnt_d = cnt_q;
    else                       cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rst_q_o <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      rst_q_o <= (cnt_d == CNT_TOP);
    end
  end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic              wr_en_i,
  input  logic [PCON_W-1:0] wr_data_i,
  input  logic              wake_i,
  output logic [PCON_W-1:0] pcon_q_o,
  output logic [PCON_W-1:0] pcon_d_o
);
  pwr_mode_e cur_mode;

  assign cur_mode = decode_mode(pcon_q_o);

  always_comb begin
    pcon_d_o = pcon_q_o;
    unique case (cur_mode)
      MODE_RUN: begin
        if (wr_en_i) begin
          pcon_d_o = wr_data_i & WR_MASK;
          if (wr_data_i[BIT_PD]) pcon_d_o[BIT_IDL] = 1'b0;
        end
      end
      MODE_IDLE: begin
        if (wake_i) pcon_d_o[BIT_IDL] = 1'b0;
      end
      default: ;
    endcase
    if (clr) pcon_d_o = '0;
  end

  always_ff @(posedge clk) begin
    if (clr) pcon_q_o <= '0;
    else     pcon_q_o <= pcon_d_o;
  end
endmodule

// File: rtl/pwr_out_drv.sv
module pwr_out_drv
  import pwr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [PCON_W-1:0] pcon_d_i,
  input  logic              rst_int_i,
  input  logic              ea_pin_i,
  output logic              cpu_ce_o,
  output logic              per_ce_o,
  output logic              strobe_hold_o,
  output logic              strobe_level_o,
  output logic              ea_o
);
  pwr_mode_e nxt_mode;

  assign nxt_mode = decode_mode(pcon_d_i);

  always_ff @(posedge clk) begin
    if (clr) begin
      cpu_ce_o       <= 1'b1;
      per_ce_o       <= 1'b1;
      strobe_hold_o  <= 1'b0;
      strobe_level_o <= 1'b0;
    end else begin
      cpu_ce_o       <= (nxt_mode == MODE_RUN);
      per_ce_o       <= (nxt_mode != MODE_PDOWN);
      strobe_hold_o  <= (nxt_mode != MODE_RUN);
      strobe_level_o <= (nxt_mode == MODE_IDLE);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            ea_o <= 1'b0;
    else if (rst_int_i) ea_o <= ea_pin_i;
  end
endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_pkg::*;
#(
  parameter int OSC_PER_MCYC = 12,
  parameter int HOLD_MCYC    = 2,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rst_pin_i,
  input  logic              ea_pin_i,
  input  logic              wr_en_i,
  input  logic [PCON_W-1:0] wr_data_i,
  input  logic              wake_i,
  output logic              cpu_ce_o,
  output logic              per_ce_o,
  output logic              strobe_hold_o,
  output logic              strobe_level_o,
  output logic              rst_int_o,
  output logic              ea_o,
  output logic [PCON_W-1:0] pcon_o
);
  localparam int HOLD_CYC = OSC_PER_MCYC * HOLD_MCYC;

  logic              clr;
  logic [PCON_W-1:0] pcon_d;

  assign clr = rst | rst_int_o;

  pwr_rst_qual #(
    .SYNC_STAGES(SYNC_STAGES),
    .HOLD_CYC   (HOLD_CYC)
  ) u_qual (
    .clk    (clk),
    .rst    (rst),
    .pin_i  (rst_pin_i),
    .rst_q_o(rst_int_o)
  );

  pwr_ctl_reg u_reg (
    .clk      (clk),
    .clr      (clr),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .wake_i   (wake_i),
    .pcon_q_o (pcon_o),
    .pcon_d_o (pcon_d)
  );

  pwr_out_drv u_drv (
    .clk           (clk),
    .rst           (rst),
    .clr           (clr),
    .pcon_d_i      (pcon_d),
    .rst_int_i     (rst_int_o),
    .ea_pin_i      (ea_pin_i),
    .cpu_ce_o      (cpu_ce_o),
    .per_ce_o      (per_ce_o),
    .strobe_hold_o (strobe_hold_o),
    .strobe_level_o(strobe_level_o),
    .ea_o          (ea_o)
  );
endmodule

// File: rtl/pwr_mode_ctl_chk.sv
module pwr_mode_ctl_chk #(
  parameter int HOLD_CYC = 24
) (
  input logic       clk,
  input logic       rst,
  input logic       rst_pin_i,
  input logic       wr_en_i,
  input logic       wake_i,
  input logic [7:0] pcon_o,
  input logic       cpu_ce_o,
  input logic       per_ce_o,
  input logic       strobe_hold_o,
  input logic       strobe_level_o,
  input logic       rst_int_o,
  input logic       ea_o
);
  localparam int CNT_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] RUN_TOP = CNT_W'(HOLD_CYC);

  logic [CNT_W-1:0] run_q;
  logic             long_q, rst_int_prev;

  // Consecutive high samples of the pin, and whether a long enough run was seen
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q        <= '0;
      long_q       <= 1'b0;
      rst_int_prev <= 1'b0;
    end else begin
      rst_int_prev <= rst_int_o;
      if (!rst_pin_i)           run_q <= '0;
      else if (run_q != RUN_TOP) run_q <= run_q + 1'b1;
      if (rst_pin_i && (run_q >= RUN_TOP - 1'b1)) long_q <= 1'b1;
      else if (rst_int_prev && !rst_int_o)        long_q <= 1'b0;
    end
  end

  assert_idle_levels_R3: assert property (@(posedge clk) disable iff (rst)
    pcon_o[0] |-> (!cpu_ce_o && per_ce_o && strobe_hold_o && strobe_level_o));

  assert_pdown_levels_R4: assert property (@(posedge clk) disable iff (rst)
    pcon_o[1] |-> (!cpu_ce_o && !per_ce_o && strobe_hold_o && !strobe_level_o));

  assert_one_mode_R5: assert property (@(posedge clk) disable iff (rst)
    !(pcon_o[0] && pcon_o[1]));

  assert_wake_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (pcon_o[0] && wake_i && !rst_int_o) |=>
      (!pcon_o[0] && pcon_o[7:1] == $past(pcon_o[7:1])));

  assert_write_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    ((pcon_o[0] || pcon_o[1]) && wr_en_i && !wake_i && !rst_int_o) |=>
      (pcon_o == $past(pcon_o)));

  assert_hold_time_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_int_o) |-> long_q);

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    rst_int_o |=> (pcon_o == 8'h00 && cpu_ce_o && per_ce_o));

  assert_strap_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !rst_int_o |=> $stable(ea_o));
endmodule

bind pwr_mode_ctl pwr_mode_ctl_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .rst_pin_i     (rst_pin_i),
  .wr_en_i       (wr_en_i),
  .wake_i        (wake_i),
  .pcon_o        (pcon_o),
  .cpu_ce_o      (cpu_ce_o),
  .per_ce_o      (per_ce_o),
  .strobe_hold_o (strobe_hold_o),
  .strobe_level_o(strobe_level_o),
  .rst_int_o     (rst_int_o),
  .ea_o          (ea_o)
);

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;
  localparam int HOLD = 24;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_pin_i = 1'b0;
  logic       ea_pin_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = 8'h00;
  logic       wake_i = 1'b0;
  logic       cpu_ce_o, per_ce_o, strobe_hold_o, strobe_level_o, rst_int_o, ea_o;
  logic [7:0] pcon_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  pwr_mode_ctl u_dut (
    .clk(clk), .rst(rst), .rst_pin_i(rst_pin_i), .ea_pin_i(ea_pin_i),
    .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .wake_i(wake_i),
    .cpu_ce_o(cpu_ce_o), .per_ce_o(per_ce_o), .strobe_hold_o(strobe_hold_o),
    .strobe_level_o(strobe_level_o), .rst_int_o(rst_int_o), .ea_o(ea_o),
    .pcon_o(pcon_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_pcon(input logic [7:0] d);
    logic [7:0] e;
    e = d & 8'h8F;
    if (e[1]) e[0] = 1'b0;
    return e;
  endfunction

  task automatic chk_levels(input string req, input logic [7:0] e);
    chk({req, " pcon"},   pcon_o, e);
    chk({req, " cpu_ce"}, cpu_ce_o, !(e[0] || e[1]));
    chk({req, " per_ce"}, per_ce_o, !e[1]);
    chk({req, " hold"},   strobe_hold_o, e[0] || e[1]);
    chk({req, " level"},  strobe_level_o, e[0] && !e[1]);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic exp_ea;
    logic seen;
    int   first;
    logic [7:0] e;

    repeat (3) tick();
    rst = 1'b0;
    tick();
    // R1 reset state
    chk_levels("R1", 8'h00);
    chk("R1 rst_int", rst_int_o, 0);
    chk("R1 ea", ea_o, 0);
    exp_ea = 1'b0;

    // Exhaustive write sweep from run mode: R2..R7, R9
    for (int d = 0; d < 256; d++) begin
      e = exp_pcon(8'(d));
      wr_en_i = 1'b1; wr_data_i = 8'(d);
      tick();
      wr_en_i = 1'b0;
      chk_levels(e[1] ? "R4" : (e[0] ? "R3" : "R2"), e);
      if (d[1:0] == 2'b11) chk("R5 idle bit", pcon_o[0], 0);
      if (e[1]) begin
        wr_en_i = 1'b1; wr_data_i = 8'h00;
        tick();
        wr_en_i = 1'b0;
        chk("R7 write in pdown", pcon_o, e);
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        chk("R6 wake in pdown", pcon_o, e);
        rst_pin_i = 1'b1;
        repeat (HOLD + 1) tick();
        chk("R8 not yet", rst_int_o, 0);
        tick();
        chk("R8 rise", rst_int_o, 1);
        tick();
        chk_levels("R9", 8'h00);
        rst_pin_i = 1'b0;
        repeat (2) tick();
        chk("R8 still high", rst_int_o, 1);
        tick();
        chk("R8 fall", rst_int_o, 0);
      end else if (e[0]) begin
        wr_en_i = 1'b1; wr_data_i = 8'hFF;
        tick();
        wr_en_i = 1'b0;
        chk("R7 write in idle", pcon_o, e);
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        chk_levels("R6 wake idle", e & 8'hFE);
        wr_en_i = 1'b1; wr_data_i = 8'h00;
        tick();
        wr_en_i = 1'b0;
      end else begin
        wake_i = 1'b1;
        tick();
        wake_i = 1'b0;
        chk("R6 wake in run", pcon_o, e);
        wr_en_i = 1'b1; wr_data_i = 8'h00;
        tick();
        wr_en_i = 1'b0;
        chk("R2 clear", pcon_o, 8'h00);
      end
    end

    // Reset pulse length sweep: R8, R9, R10
    for (int n = 1; n <= 30; n++) begin
      wake_i = 1'b1;
      tick();
      wake_i = 1'b0;
      wr_en_i = 1'b1; wr_data_i = 8'h01;
      tick();
      wr_en_i = 1'b0;
      ea_pin_i = n[0];
      seen = 1'b0;
      first = 0;
      rst_pin_i = 1'b1;
      for (int t = 1; t <= n + 6; t++) begin
        if (t == n + 1) rst_pin_i = 1'b0;
        tick();
        if (rst_int_o && !seen) begin
          seen = 1'b1;
          first = t;
        end
      end
      chk("R8 threshold", seen, n >= HOLD);
      if (n >= HOLD) begin
        chk("R8 rise edge", first, HOLD + 2);
        exp_ea = n[0];
      end
      chk("R9 idle cleared", pcon_o, (n >= HOLD) ? 8'h00 : 8'h01);
      ea_pin_i = ~ea_pin_i;
      repeat (2) tick();
      chk("R10 strap", ea_o, exp_ea);
    end

    finish_run();
  end
endmodule